// File: doc/BRIEF.md
# Multi-Step Pseudo-Random Bit Generator

This block produces a pseudo-random bit stream from a small shift register with XNOR feedback, and it moves that register forward several serial steps in a single clock. The parallel word it presents after each enabled clock holds the most recent serial bits, with the oldest bit in the most significant position. Because the state moves as many steps as the word is wide, the bits in one word do not overlap the bits in the previous word. A narrow word read once per clock from a one-step register would contain only shifted copies of bits already seen.

The number of serial steps per clock is fixed at build time: 1, 4 or 8. The word is four bits wide for 1 and 4 steps and eight bits wide for 8 steps. In every case the feedback taps are bits 3 and 2, so the low four bits always follow the same period-15 sequence. A reference input switches the block to one serial step per clock so that a bench can compare the fast path against plain serial stepping on the same hardware. A clock enable freezes the state, and a synchronous reset clears it.

Top module: `prng_multistep`

## Requirements
- R1: When `rst` is high at a rising clock edge, `word_o` becomes all zeros on that edge, whatever `en` and `ref_mode` are.
- R2: With `ref_mode` high and `en` high, each clock moves the word one serial step. The new word is the old word shifted left by one place, and the new bit 0 is XNOR of the old bits 3 and 2.
- R3: In reference mode after reset, bit 0 of the word reads 0,1,1,1,0,1,1,0,0,1,0,1,0,0,0 on successive clocks, with the first value taken straight after reset. The pattern repeats with period 15.
- R4: With `ref_mode` low and `en` high, each clock moves the word exactly STEPS serial steps. The result equals the word reached after STEPS reference-mode clocks from the same state.
- R5: For STEPS = 4 in fast mode, each clock maps old bits s3..s0 as follows: new bit 0 is s0 XOR s3 XOR s2, new bit 1 is XNOR(s1, s0), new bit 2 is XNOR(s2, s1) and new bit 3 is XNOR(s3, s2).
- R6: For STEPS = 8 the word is 8 bits wide and holds the last eight serial bits, oldest in bit 7. Its low four bits match a 4-bit generator that has taken the same number of serial steps.
- R7: While `en` is low and `rst` is low, `word_o` keeps its value in either mode.
- R8: Starting from reset, the low four bits of the word are never all ones.
- R9: For STEPS = 1, fast mode and reference mode give the same next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; the state holds when low |
| ref_mode | input | 1 | High selects one serial step per clock; low selects STEPS steps per clock |
| word_o | output | W (4, or 8 when STEPS = 8) | Current register state; bit 0 is the newest serial bit |

## Verification
The bench runs three builds at once (1, 4 and 8 steps per clock) and checks every word against an arithmetic serial model indexed by the total number of serial steps taken. An error in a look-ahead term or in the step count would show up as a wrong word in the very first fast cycle. A wrong tap pair or feedback polarity would break the fixed 15-bit pattern, and an XOR in place of XNOR would also lock the register at zero. Enable toggling interleaved with mode switching exposes any state change during a held cycle. A reset applied mid-run while enabled shows whether reset loses to the enable.

// File: rtl/prng_pkg.sv
package prng_pkg;

    // Width and tap placement of the base serial register.
    localparam int BASE_W = 4;
    localparam int TAP_HI = 3;
    localparam int TAP_LO = 2;

    // Advance selection: one serial step, or the built-in multi-step path.
    typedef enum logic {
        ADV_FAST = 1'b0,
        ADV_REF  = 1'b1
    } adv_mode_e;

    typedef struct packed {
        logic      load;
        adv_mode_e mode;
    } adv_ctrl_t;

    function automatic int word_width(input int steps);
        return (steps > BASE_W) ? steps : BASE_W;
    endfunction

    // Feedback bit entering the low end of the register.
    function automatic logic fb_bit(input logic hi, input logic lo);
        return ~(hi ^ lo);
    endfunction

endpackage

// File: rtl/prng_adv_net.sv
module prng_adv_net
    import prng_pkg::*;
#(
    parameter int W = 4,
    parameter int N = 4
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);

    // One serial step: shift toward the MSB, feedback into bit 0.
    function automatic logic [W-1:0] one_step(input logic [W-1:0] s);
        return {s[W-2:0], fb_bit(s[TAP_HI], s[TAP_LO])};
    endfunction

    generate
        if (N == 4 && W == 4) begin : g_four
            // Closed-form four-step look-ahead.
            always_comb begin
                nxt_o[0] = cur_i[0] ^ cur_i[3] ^ cur_i[2];
                nxt_o[1] = ~(cur_i[1] ^ cur_i[0]);
                nxt_o[2] = ~(cur_i[2] ^ cur_i[1]);
                nxt_o[3] = ~(cur_i[3] ^ cur_i[2]);
            end
        end else begin : g_unrolled
            // Generic look-ahead: N serial steps flattened into one cone.
            always_comb begin
                logic [W-1:0] acc;
                acc = cur_i;
                for (int k = 0; k < N; k++) begin
                    acc = one_step(acc);
                end
                nxt_o = acc;
            end
        end
    endgenerate

endmodule

// File: rtl/prng_state_reg.sv
module prng_state_reg
    import prng_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  adv_ctrl_t    ctrl_i,
    input  logic [W-1:0] nxt_fast_i,
    input  logic [W-1:0] nxt_ref_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (ctrl_i.load) begin
            state_q <= (ctrl_i.mode == ADV_REF) ? nxt_ref_i : nxt_fast_i;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/prng_multistep.sv
module prng_multistep
    import prng_pkg::*;
#(
    parameter  int STEPS = 4,
    localparam int W     = word_width(STEPS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ref_mode,
    output logic [W-1:0] word_o
);

    logic [W-1:0] state;
    logic [W-1:0] nxt_fast;
    logic [W-1:0] nxt_ref;
    adv_ctrl_t    ctrl;

    always_comb begin
        ctrl.load = en;
        ctrl.mode = ref_mode ? ADV_REF : ADV_FAST;
    end

    prng_adv_net #(.W(W), .N(STEPS)) u_fast (
        .cur_i (state),
        .nxt_o (nxt_fast)
    );

    prng_adv_net #(.W(W), .N(1)) u_ref (
        .cur_i (state),
        .nxt_o (nxt_ref)
    );

    prng_state_reg #(.W(W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .ctrl_i     (ctrl),
        .nxt_fast_i (nxt_fast),
        .nxt_ref_i  (nxt_ref),
        .state_o    (state)
    );

    assign word_o = state;

endmodule

// File: rtl/prng_multistep_chk.sv
module prng_multistep_chk #(
    parameter int W = 4,
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         ref_mode,
    input logic [W-1:0] word
);

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        word[3:0] != 4'hF); // R8

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(word)); // R7

    AST_REF_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (en && ref_mode) |=> word[W-1:1] == $past(word[W-2:0])); // R2

    AST_REF_NEWBIT: assert property (@(posedge clk) disable iff (rst)
        (en && ref_mode) |=> word[0] == ~($past(word[3]) ^ $past(word[2]))); // R2

    generate
        if (N == W) begin : g_full_refresh
            AST_FAST_OLDEST: assert property (@(posedge clk) disable iff (rst)
                (en && !ref_mode) |=> word[W-1] == ~($past(word[3]) ^ $past(word[2]))); // R4
        end
    endgenerate

endmodule

bind prng_multistep prng_multistep_chk #(.W(W), .N(STEPS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ref_mode (ref_mode),
    .word     (word_o)
);

// File: tb/sim_prng_multistep.sv
module sim_prng_multistep;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       ref_mode = 1'b1;
    logic [3:0] w4;
    logic [7:0] w8;
    logic [3:0] w1;

    int vectors = 0;
    int errors  = 0;
    int n4 = 0;
    int n8 = 0;
    int n1 = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prng_multistep #(.STEPS(4)) u0 (.clk(clk), .rst(rst), .en(en), .ref_mode(ref_mode), .word_o(w4));
    prng_multistep #(.STEPS(8)) u1 (.clk(clk), .rst(rst), .en(en), .ref_mode(ref_mode), .word_o(w8));
    prng_multistep #(.STEPS(1)) u2 (.clk(clk), .rst(rst), .en(en), .ref_mode(ref_mode), .word_o(w1));

    // Serial model: state after t single steps from zero, 8 bits kept.
    function automatic logic [7:0] model(input int t);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < t; i++) s = {s[6:0], ~(s[3] ^ s[2])};
        return s;
    endfunction

    localparam logic [14:0] PATTERN = 15'b000101001101110; // bit t = serial bit at step t

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string tag);
        chk(w4 == model(n4)[3:0], {tag, " u0"}, {4'h0, w4}, {4'h0, model(n4)[3:0]});
        chk(w8 == model(n8),      {tag, " u1"}, w8, model(n8));
        chk(w1 == model(n1)[3:0], {tag, " u2"}, {4'h0, w1}, {4'h0, model(n1)[3:0]});
        chk(w4 != 4'hF && w8[3:0] != 4'hF && w1 != 4'hF, "R8 lockup", {4'h0, w4}, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] prev4;
        logic [7:0] prev8;
        logic [3:0] e4;
        #1;
        tick();
        tick();
        // R1: reset state
        chk(w4 == 4'h0 && w8 == 8'h00 && w1 == 4'h0, "R1 reset", w8, 8'h00);

        // R2/R3: reference mode, one serial step per clock
        rst = 1'b0;
        en = 1'b1;
        ref_mode = 1'b1;
        for (int i = 0; i < 32; i++) begin
            chk(w1[0] == PATTERN[n1 % 15], "R3 serial bit", {7'h0, w1[0]}, {7'h0, PATTERN[n1 % 15]});
            prev4 = w4;
            tick();
            n4++; n8++; n1++;
            chk(w4 == {prev4[2:0], ~(prev4[3] ^ prev4[2])}, "R2 ref step", {4'h0, w4},
                {4'h0, prev4[2:0], ~(prev4[3] ^ prev4[2])});
            check_all("R2");
        end
        // R3: period 15
        prev8 = w8;
        for (int i = 0; i < 15; i++) begin
            tick();
            n4++; n8++; n1++;
        end
        chk(w8[3:0] == prev8[3:0], "R3 period", {4'h0, w8[3:0]}, {4'h0, prev8[3:0]});

        // R4/R5/R6/R9: fast mode
        ref_mode = 1'b0;
        for (int i = 0; i < 40; i++) begin
            prev4 = w4;
            tick();
            n4 += 4; n8 += 8; n1 += 1;
            e4 = {~(prev4[3] ^ prev4[2]), ~(prev4[2] ^ prev4[1]),
                  ~(prev4[1] ^ prev4[0]), prev4[0] ^ prev4[3] ^ prev4[2]};
            chk(w4 == e4, "R5 four-step terms", {4'h0, w4}, {4'h0, e4});
            chk(w8[3:0] == model(n8)[3:0], "R6 low nibble", {4'h0, w8[3:0]}, {4'h0, model(n8)[3:0]});
            check_all("R4 R9");
        end

        // R7: enable toggling mixed with mode switching
        for (int i = 0; i < 60; i++) begin
            en = (i % 3) != 0;
            ref_mode = (i % 2) == 1;
            prev4 = w4;
            prev8 = w8;
            tick();
            if (en) begin
                n4 += ref_mode ? 1 : 4;
                n8 += ref_mode ? 1 : 8;
                n1 += 1;
            end else begin
                chk(w4 == prev4 && w8 == prev8, "R7 hold", w8, prev8);
            end
            check_all("R7");
        end

        // R1: reset mid-run with enable high wins
        en = 1'b1;
        ref_mode = 1'b0;
        rst = 1'b1;
        tick();
        chk(w4 == 4'h0 && w8 == 8'h00 && w1 == 4'h0, "R1 mid-run reset", w8, 8'h00);
        n4 = 0; n8 = 0; n1 = 0;
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick();
            n4 += 4; n8 += 8; n1 += 1;
            check_all("R4 after reset");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule